// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Target

This block is the bus-facing half of a small serial peripheral. It listens to a two-wire bus (clock line and data line, both idle high) and samples both lines with a fast system clock. Each line passes through a two-flop synchronizer and a persistence filter. A level change reaches the core logic only after it has held for `FILT_LEN` consecutive system clocks, so short spikes are ignored.

The core finds bus conditions. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. Between those conditions the core shifts in bytes MSB first, sampling data on each clock-line rising edge. The first byte after every START is the address byte. Its upper seven bits must equal the seven-bit target address and its last bit must be 0, which marks a write.

The target address is `0101` followed by three strap bits. With `OCTAL` set, the three low bits are instead `0` followed by the two lowest strap bits. When the address matches, the block pulls the data line low through `sda_oe` for the ninth clock of the address byte and of every byte after it. Each received data byte is handed downstream as `rx_byte` with a one-cycle `byte_valid` and a running `byte_index`. START and STOP are reported as one-cycle pulses. An aborted final byte is flagged with `abort_evt`.

Top module: `twowire_rx_slave`

## Requirements
- R1: After reset, `sda_oe`, `byte_valid`, `start_evt`, `stop_evt` and `abort_evt` are 0, `byte_index` is 0 and `rx_byte` is 0.
- R2: Every START, including a repeated START with no STOP before it, produces a one-cycle `start_evt`, and `byte_index` reads 0 in the cycle after it.
- R3: An address byte whose first seven bits are `0101` followed by `strap[2:0]` (or `0101 0 strap[1:0]` when `OCTAL`=1), and whose eighth bit is 0, is acknowledged: the bus data line is low while the clock line is high during the ninth clock.
- R4: An address byte with a different address, or with its eighth bit 1, is not acknowledged. The bytes that follow it in the same transfer are neither acknowledged nor delivered, and the STOP that ends the transfer produces no `stop_evt`.
- R5: In a matched transfer, each complete data byte is delivered MSB first on `rx_byte` with a one-cycle `byte_valid`. `byte_index` counts 0, 1, 2, … from the last START, and every data byte is acknowledged.
- R6: A STOP produces a one-cycle `stop_evt` only while the block is the addressed target. `stop_evt`, `start_evt` and `byte_valid` never coincide.
- R7: A STOP that arrives after at least one data bit of an unfinished byte raises `abort_evt` together with `stop_evt`. The partial byte is not delivered. A STOP that follows an acknowledged byte gives `abort_evt`=0.
- R8: A repeated START followed by an address of another target drops the selection. No `stop_evt` is reported, and later bytes are neither delivered nor acknowledged.
- R9: A pulse on either line that lasts fewer than `FILT_LEN` system clocks has no effect. It adds no bit, creates no START or STOP, and leaves the delivered byte unchanged.
- R10: `sda_oe` is 1 only during the acknowledge clock. It is 0 whenever the clock line is high during data bits and after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap | input | 3 | Low address bits from board straps |
| sda_oe | output | 1 | 1 pulls the data line low (open drain); 0 releases it |
| rx_byte | output | 8 | Last data byte received |
| byte_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| byte_index | output | IDXW | Position of the delivered byte since the last START |
| start_evt | output | 1 | One-cycle pulse on START or repeated START |
| stop_evt | output | 1 | One-cycle pulse on STOP while addressed |
| abort_evt | output | 1 | With `stop_evt`: the STOP cut a byte short |

## Verification
The hardest situation to reach from the ports is a selection being lost without a STOP. This happens when a repeated START re-addresses the bus to another target midway through a matched transfer. The stimulus opens a matched write, sends one byte, and then issues a repeated START with a foreign address. It follows this with bytes and a STOP that must all go unreported. Spike rejection is also driven directly. Pulses two system clocks wide are injected on the clock line while it is low, and on the data line while the clock is high. Either pulse would forge a bit, a START or a STOP if it got through.

// File: rtl/twowire_rx_slave.sv
module twowire_rx_slave #(
  parameter int FILT_LEN = 3,
  parameter bit OCTAL    = 1'b0,
  parameter int IDXW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [2:0]      strap,
  output logic            sda_oe,
  output logic [7:0]      rx_byte,
  output logic            byte_valid,
  output logic [IDXW-1:0] byte_index,
  output logic            start_evt,
  output logic            stop_evt,
  output logic            abort_evt
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [3:0] PREFIX = 4'b0101;

  logic [1:0] pad, filt;
  assign pad = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [1:0]    sy;
    logic [CW-1:0] ct;
    logic          fq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sy <= 2'b11;
        ct <= '0;
        fq <= 1'b1;
      end else begin
        sy <= {sy[0], pad[g]};
        if (sy[1] != fq) begin
          if (ct == CW'(FILT_LEN - 1)) begin
            fq <= sy[1];
            ct <= '0;
          end else begin
            ct <= ct + 1'b1;
          end
        end else begin
          ct <= '0;
        end
      end
    end
    assign filt[g] = fq;
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  logic [6:0] own_addr;
  assign own_addr = OCTAL ? {PREFIX, 1'b0, strap[1:0]} : {PREFIX, strap};

  logic cond_start, cond_stop, scl_rise, scl_fall;
  assign cond_start = scl_f & scl_q & sda_q & ~sda_f;
  assign cond_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise   = scl_f & ~scl_q;
  assign scl_fall   = ~scl_f & scl_q;

  logic       active, addr_ph, selected, in_ack;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      active     <= 1'b0;
      addr_ph    <= 1'b0;
      selected   <= 1'b0;
      in_ack     <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_oe     <= 1'b0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      byte_index <= '0;
      start_evt  <= 1'b0;
      stop_evt   <= 1'b0;
      abort_evt  <= 1'b0;
    end else begin
      scl_q      <= scl_f;
      sda_q      <= sda_f;
      byte_valid <= 1'b0;
      start_evt  <= 1'b0;
      stop_evt   <= 1'b0;
      abort_evt  <= 1'b0;
      if (byte_valid) byte_index <= byte_index + 1'b1;

      if (cond_start) begin
        active     <= 1'b1;
        addr_ph    <= 1'b1;
        selected   <= 1'b0;
        in_ack     <= 1'b0;
        bit_cnt    <= '0;
        sda_oe     <= 1'b0;
        byte_index <= '0;
        start_evt  <= 1'b1;
      end else if (cond_stop) begin
        if (selected) begin
          stop_evt  <= 1'b1;
          abort_evt <= !in_ack && (bit_cnt > 4'd1);
        end
        active   <= 1'b0;
        addr_ph  <= 1'b0;
        selected <= 1'b0;
        in_ack   <= 1'b0;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
      end else if (active) begin
        if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_f};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
          end else if (bit_cnt == 4'd8) begin
            if (addr_ph) begin
              addr_ph <= 1'b0;
              if (shreg == {own_addr, 1'b0}) begin
                selected <= 1'b1;
                in_ack   <= 1'b1;
                sda_oe   <= 1'b1;
              end else begin
                active <= 1'b0;
              end
            end else begin
              rx_byte    <= shreg;
              byte_valid <= 1'b1;
              in_ack     <= 1'b1;
              sda_oe     <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/twowire_rx_slave_chk.sv
module twowire_rx_slave_chk #(
  parameter int IDXW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sda_oe,
  input logic            byte_valid,
  input logic [IDXW-1:0] byte_index,
  input logic            start_evt,
  input logic            stop_evt,
  input logic            abort_evt
);
  assert_idx_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> byte_index == '0);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> byte_index == IDXW'($past(byte_index) + 1'b1));

  assert_events_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, byte_valid}));

  assert_abort_with_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> stop_evt);

  assert_ack_with_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> sda_oe);

  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> !sda_oe);
endmodule

bind twowire_rx_slave twowire_rx_slave_chk #(.IDXW(IDXW)) u_chk (.*);

// File: tb/sim_twowire_rx_slave.sv
`timescale 1ns/1ps
module sim_twowire_rx_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe, byte_valid, start_evt, stop_evt, abort_evt;
  logic [7:0] rx_byte, byte_index;
  wire bus_sda = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  twowire_rx_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda), .strap(strap),
    .sda_oe(sda_oe), .rx_byte(rx_byte), .byte_valid(byte_valid),
    .byte_index(byte_index), .start_evt(start_evt), .stop_evt(stop_evt),
    .abort_evt(abort_evt)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] data;
    logic [7:0] idx;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0, n_bad = 0;
  string ctx = "R1";
  bit    done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [7:0] d, input logic [7:0] i);
    exp_t e;
    e.kind = k; e.data = d; e.idx = i;
    q.push_back(e);
  endtask

  task automatic got(input logic [1:0] k, input logic [7:0] d, input logic [7:0] i, input string req);
    exp_t e;
    if (q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s (%s): actual unexpected event kind %0d expected none", ctx, req, k);
    end else begin
      e = q.pop_front();
      check({req, " kind"}, k, e.kind);
      if (k == 2'd1) begin
        check({req, " data"}, d, e.data);
        check({req, " index"}, i, e.idx);
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (start_evt)  got(2'd0, 8'h00, 8'h00, "R2 start");
    if (byte_valid) got(2'd1, rx_byte, byte_index, "R5 byte");
    if (stop_evt)   got(abort_evt ? 2'd3 : 2'd2, 8'h00, 8'h00, "R6/R7 stop");
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(2 * Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; waitq(Q / 2);
    if (glitch) begin
      scl_m = 1'b1; waitq(2); scl_m = 1'b0;
    end
    waitq(Q - Q / 2);
    scl_m = 1'b1; waitq(Q / 2);
    if (glitch) begin
      sda_m = ~b; waitq(2); sda_m = b;
    end
    check("R10 released", sda_oe, 0);
    waitq(2 * Q - Q / 2);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input bit glitch, input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    check({req, " ack"}, bus_sda, ack ? 0 : 1);
    waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  initial begin
    waitq(5);
    rst_n = 1'b1;
    waitq(2);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 byte_valid", byte_valid, 0);
    check("R1 events", {start_evt, stop_evt, abort_evt}, 0);
    check("R1 byte_index", byte_index, 0);
    check("R1 rx_byte", rx_byte, 0);

    ctx = "R5";
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5A, 1, 0, "R3 own address");
    expect_ev(1, 8'h12, 0); send_byte(8'h12, 1, 0, "R5 byte0");
    expect_ev(1, 8'hA5, 1); send_byte(8'hA5, 1, 0, "R5 byte1");
    expect_ev(1, 8'h00, 2); send_byte(8'h00, 1, 0, "R5 byte2");
    expect_ev(2, 0, 0);
    bus_stop();
    check("R10 after stop", sda_oe, 0);

    ctx = "R4";
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5C, 0, 0, "R4 foreign address");
    send_byte(8'h33, 0, 0, "R4 ignored byte");
    bus_stop();

    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5B, 0, 0, "R4 read bit");
    send_byte(8'h66, 0, 0, "R4 ignored byte after read");
    bus_stop();

    ctx = "R7";
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5A, 1, 0, "R3 address");
    expect_ev(1, 8'h77, 0); send_byte(8'h77, 1, 0, "R7 full byte");
    send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
    expect_ev(3, 0, 0);
    bus_stop();

    ctx = "R8";
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5A, 1, 0, "R3 address");
    expect_ev(1, 8'h11, 0); send_byte(8'h11, 1, 0, "R8 before restart");
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h50, 0, 0, "R8 other target");
    send_byte(8'h22, 0, 0, "R8 byte for other");
    bus_stop();

    ctx = "R2";
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5A, 1, 0, "R3 address");
    expect_ev(1, 8'h44, 0); send_byte(8'h44, 1, 0, "R2 first");
    expect_ev(1, 8'h45, 1); send_byte(8'h45, 1, 0, "R2 second");
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5A, 1, 0, "R3 readdress");
    expect_ev(1, 8'h55, 0); send_byte(8'h55, 1, 0, "R2 index restarts");
    expect_ev(2, 0, 0);
    bus_stop();

    ctx = "R9";
    expect_ev(0, 0, 0);
    bus_start();
    send_byte(8'h5A, 1, 1, "R9 address with spikes");
    expect_ev(1, 8'hC3, 0); send_byte(8'hC3, 1, 1, "R9 byte with spikes");
    expect_ev(2, 0, 0);
    bus_stop();

    waitq(20);
    check("R6 pending events", q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (%s): actual timeout expected completion", ctx);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule